// File: doc/BRIEF.md
# Encoded-Ratio System Clock Divider

This block turns one PLL-derived source clock into four clock-enable strobes, one each for the CPU, memory, high-speed peripheral and low-speed peripheral domains. The block runs on a fast system clock. A per-cycle qualifier marks the cycles that count as source clock cycles. When the bypass flag is clear, the qualifier comes from the multiplied PLL. When the flag is set, it comes from the external reference. Each domain strobe is one cycle wide and repeats every N source cycles. N is taken from a 4-bit code through a non-linear ratio table, which includes the odd ratio 3. Codes beyond the table saturate to the largest ratio.

A 32-bit control word holds the four codes, the full/half rate selection for secondary users and a change-enable flag. Software writes the word through a simple write strobe and reads it back combinationally. New codes are moved into the live dividers only while change-enable is set. The move happens at the next source cycle in which all four domains wrap together, so no domain ever produces a shortened period. A fifth strobe serves secondary users. It follows the full source rate or half of it, as the rate-selection bit of the control word chooses.

Top module: `sysclk_ratio_div`

## Requirements
- R1: After reset the control word reads 0 and every domain strobe fires on every source cycle, all four together.
- R2: The codes live at bits 3:0 (CPU, dom_stb[0]), 7:4 (high-speed, dom_stb[1]), 11:8 (low-speed, dom_stb[2]) and 15:12 (memory, dom_stb[3]). Codes 0..9 give a strobe every 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32 source cycles respectively.
- R3: A code from 10 to 15 divides by 32, the same as code 9.
- R4: rd_data returns bits 15:0, 21 and 22 exactly as last written, including out-of-range codes. All other bits read 0.
- R5: A write with bit 22 clear changes the read-back value but leaves the strobe spacing of every domain unchanged.
- R6: While bit 22 is set, written codes are applied at the next source cycle in which all four domains strobe. That cycle still carries the old-ratio strobes, and the new ratios count from the following source cycle.
- R7: With pll_bypass low, only pll_tick marks a source cycle. With pll_bypass high, only ref_tick does.
- R8: Cycles without a source tick produce no strobe and do not advance any divider.
- R9: aux_full mirrors bit 21. When it is 1, aux_stb fires on every source cycle. When it is 0, aux_stb fires on every second source cycle and never on two consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read-back |
| pll_bypass | input | 1 | 1: source cycles come from ref_tick |
| pll_tick | input | 1 | Source-cycle qualifier from the multiplied PLL |
| ref_tick | input | 1 | Source-cycle qualifier from the external reference |
| dom_stb | output | 4 | Domain strobes: 0 CPU, 1 high-speed, 2 low-speed, 3 memory |
| aux_stb | output | 1 | Secondary-user strobe, full or half source rate |
| aux_full | output | 1 | Level of the full-rate selection bit |

## Verification
Two functions can fall in the same source cycle: the old-ratio strobes of the all-domain wrap, and the loading of new codes. The bench sets mixed ratios of 2 and 3, so the domains wrap together every six source cycles. It waits until all four strobes fire together. In the idle cycle that follows, it writes a new code with change-enable set. It then checks the exact strobe vector of each of the next nine source cycles. The sixth cycle must still show the full old-ratio vector, and the cycles after it must show only the new CPU spacing.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;

    localparam int NUM_DOM   = 4;
    localparam int CODE_W    = 4;
    localparam int NUM_CODES = 10;
    localparam int MAX_RATIO = 32;
    localparam int CNT_W     = $clog2(MAX_RATIO);
    localparam int WORD_W    = 32;
    localparam int FULL_BIT  = 21;
    localparam int CHG_BIT   = 22;
    localparam int CODES_W   = NUM_DOM * CODE_W;

    typedef enum logic [1:0] {
        DOM_CPU = 2'd0,
        DOM_HSP = 2'd1,
        DOM_LSP = 2'd2,
        DOM_MEM = 2'd3
    } dom_e;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic                     chg_en;
        logic                     full_rate;
        code_t [NUM_DOM-1:0]      codes;
    } ctrl_t;

    // Terminal count (ratio minus one) for a ratio code, saturating past the table.
    function automatic cnt_t term_of(input code_t c);
        int k;
        int r;
        k = (int'(c) > NUM_CODES - 1) ? NUM_CODES - 1 : int'(c);
        if (k == 0)
            r = 1;
        else if ((k % 2) == 1)
            r = 1 << ((k + 1) / 2);
        else
            r = 3 << (k / 2 - 1);
        return cnt_t'(r - 1);
    endfunction

endpackage

// File: rtl/sysdiv_ctrl.sv
module sysdiv_ctrl
    import sysdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic [WORD_W-1:0] rd_data
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[WORD_W-1:CHG_BIT+1], wr_data[FULL_BIT-1:CODES_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.chg_en    <= wr_data[CHG_BIT];
            ctrl_q.full_rate <= wr_data[FULL_BIT];
            ctrl_q.codes     <= wr_data[CODES_W-1:0];
        end
    end

    always_comb begin
        rd_data                 = '0;
        rd_data[CODES_W-1:0]    = ctrl_q.codes;
        rd_data[FULL_BIT]       = ctrl_q.full_rate;
        rd_data[CHG_BIT]        = ctrl_q.chg_en;
    end

endmodule

// File: rtl/sysdiv_dom_cnt.sv
module sysdiv_dom_cnt
    import sysdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  src_tick,
    input  logic  load,
    input  code_t code_in,
    output logic  at_wrap,
    output logic  stb
);

    cnt_t cnt_q;
    cnt_t term_q;

    assign at_wrap = (cnt_q == term_q);
    assign stb     = src_tick & at_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            term_q <= '0;
        end else begin
            if (src_tick) begin
                if (at_wrap)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + cnt_t'(1);
            end
            if (load)
                term_q <= term_of(code_in);
        end
    end

endmodule

// File: rtl/sysdiv_aux.sv
module sysdiv_aux (
    input  logic clk,
    input  logic rst,
    input  logic src_tick,
    input  logic full_rate,
    output logic aux_stb
);

    logic phase_q;

    assign aux_stb = src_tick & (full_rate | phase_q);

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= 1'b0;
        else if (src_tick)
            phase_q <= ~phase_q;
    end

endmodule

// File: rtl/sysclk_ratio_div.sv
module sysclk_ratio_div
    import sysdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pll_bypass,
    input  logic              pll_tick,
    input  logic              ref_tick,
    output logic [NUM_DOM-1:0] dom_stb,
    output logic              aux_stb,
    output logic              aux_full
);

    ctrl_t              ctrl_q;
    logic               src_tick;
    logic [NUM_DOM-1:0] wrap_vec;
    logic               all_wrap;
    logic               load_codes;

    assign src_tick   = pll_bypass ? ref_tick : pll_tick;
    assign all_wrap   = src_tick & (&wrap_vec);
    assign load_codes = all_wrap & ctrl_q.chg_en;
    assign aux_full   = ctrl_q.full_rate;

    sysdiv_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .rd_data (rd_data)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        sysdiv_dom_cnt u_cnt (
            .clk      (clk),
            .rst      (rst),
            .src_tick (src_tick),
            .load     (load_codes),
            .code_in  (ctrl_q.codes[d]),
            .at_wrap  (wrap_vec[d]),
            .stb      (dom_stb[d])
        );
    end

    sysdiv_aux u_aux (
        .clk       (clk),
        .rst       (rst),
        .src_tick  (src_tick),
        .full_rate (ctrl_q.full_rate),
        .aux_stb   (aux_stb)
    );

endmodule

// File: rtl/sysclk_ratio_div_chk.sv
module sysclk_ratio_div_chk (
    input logic        clk,
    input logic        rst,
    input logic        pll_bypass,
    input logic        pll_tick,
    input logic        ref_tick,
    input logic [31:0] rd_data,
    input logic [3:0]  dom_stb,
    input logic        aux_stb,
    input logic        aux_full
);

    logic sel_tick;
    assign sel_tick = pll_bypass ? ref_tick : pll_tick;

    // R1: first source cycle after reset strobes all domains together
    a_r1_aligned_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && sel_tick) |-> (dom_stb == 4'hF));

    // R8: no strobe without a selected source tick
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !sel_tick |-> (dom_stb == 4'h0 && !aux_stb));

    // R9: full rate gives an aux strobe on every source tick
    a_r9_full_every_tick: assert property (@(posedge clk) disable iff (rst)
        (aux_full && sel_tick) |-> aux_stb);

    // R9: half rate never gives aux strobes on consecutive cycles
    a_r9_half_no_repeat: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !aux_full && $past(!aux_full) && $past(aux_stb)) |-> !aux_stb);

    // R4: bits outside the code, rate and change fields read zero
    a_r4_unused_zero: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((rd_data & ~32'h0060_FFFF) == 32'h0));

endmodule

bind sysclk_ratio_div sysclk_ratio_div_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pll_bypass (pll_bypass),
    .pll_tick   (pll_tick),
    .ref_tick   (ref_tick),
    .rd_data    (rd_data),
    .dom_stb    (dom_stb),
    .aux_stb    (aux_stb),
    .aux_full   (aux_full)
);

// File: tb/sim_sysclk_ratio_div.sv
`timescale 1ns/1ps
module sim_sysclk_ratio_div;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pll_bypass = 1'b0;
    logic        pll_tick = 1'b0;
    logic        ref_tick = 1'b0;
    logic [3:0]  dom_stb;
    logic        aux_stb;
    logic        aux_full;

    logic [3:0]  s_stb;
    logic        s_aux;
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    sysclk_ratio_div u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pll_bypass(pll_bypass), .pll_tick(pll_tick), .ref_tick(ref_tick),
        .dom_stb(dom_stb), .aux_stb(aux_stb), .aux_full(aux_full)
    );

    function automatic int exp_ratio(input int code);
        int tbl [10] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 32};
        return tbl[(code > 9) ? 9 : code];
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic pt, input logic rt);
        @(negedge clk);
        wr_en    = 1'b0;
        pll_tick = pt;
        ref_tick = rt;
        #2;
        s_stb = dom_stb;
        s_aux = aux_stb;
    endtask

    task automatic write_ctrl(input logic [31:0] v);
        @(negedge clk);
        pll_tick = 1'b0;
        ref_tick = 1'b0;
        wr_en    = 1'b1;
        wr_data  = v;
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    task automatic measure(input int d, input int expn, input string tag);
        int n;
        bit seen;
        seen = 0;
        for (int i = 0; i < 80 && !seen; i++) begin
            step(1'b1, 1'b0);
            if (s_stb[d]) seen = 1;
        end
        n = 0;
        for (int i = 0; i < 80; i++) begin
            step(1'b1, 1'b0);
            n++;
            if (s_stb[d]) break;
        end
        chk(n == expn, tag, n, expn);
    endtask

    task automatic t_r1_reset();
        chk(rd_data == 32'h0, "R1 readback after reset", rd_data, 0);
        chk(aux_full == 1'b0, "R1 aux_full after reset", aux_full, 0);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0);
            chk(s_stb == 4'hF, "R1 aligned strobes", s_stb, 4'hF);
        end
    endtask

    task automatic t_r2_table();
        logic [15:0] sets [3] = '{16'h3210, 16'h7654, 16'h0198};
        foreach (sets[s]) begin
            write_ctrl({16'h0040, sets[s]});
            run_ticks(100);
            for (int d = 0; d < 4; d++)
                measure(d, exp_ratio(int'(sets[s][d*4 +: 4])), "R2 ratio per code and field");
        end
    endtask

    task automatic t_r3_r4_saturate();
        write_ctrl(32'hFFFF_FFFF);
        chk(rd_data == 32'h0060_FFFF, "R4 readback all ones", rd_data, 32'h0060_FFFF);
        write_ctrl(32'h0040_BC9D);
        chk(rd_data == 32'h0040_BC9D, "R4 readback out-of-range codes", rd_data, 32'h0040_BC9D);
        run_ticks(100);
        measure(0, 32, "R3 code 13 divides by 32");
        measure(1, 32, "R3 code 9 divides by 32");
        measure(2, 32, "R3 code 12 divides by 32");
        measure(3, 32, "R3 code 11 divides by 32");
    endtask

    task automatic t_r5_no_enable();
        write_ctrl(32'h0040_1111);
        run_ticks(100);
        write_ctrl(32'h0000_3333);
        chk(rd_data == 32'h0000_3333, "R5 readback without enable", rd_data, 32'h3333);
        run_ticks(100);
        measure(0, 2, "R5 cpu spacing kept");
        measure(3, 2, "R5 mem spacing kept");
    endtask

    task automatic t_r6_sync_apply();
        logic [3:0] expv [9] = '{4'hC, 4'hD, 4'hE, 4'hD, 4'hC, 4'hF, 4'hD, 4'hD, 4'hF};
        bit seen;
        write_ctrl(32'h0040_0021);
        run_ticks(100);
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            step(1'b1, 1'b0);
            if (s_stb == 4'hF) seen = 1;
        end
        chk(seen, "R6 all-domain wrap found", seen, 1);
        write_ctrl(32'h0040_0020);
        for (int i = 0; i < 9; i++) begin
            step(1'b1, 1'b0);
            chk(s_stb == expv[i], "R6 load at common wrap", s_stb, expv[i]);
        end
    endtask

    task automatic t_r7_r8_source();
        write_ctrl(32'h0040_0000);
        run_ticks(4);
        pll_bypass = 1'b0;
        step(1'b0, 1'b1);
        chk(s_stb == 4'h0, "R7 ref_tick ignored without bypass", s_stb, 0);
        step(1'b1, 1'b0);
        chk(s_stb == 4'hF, "R7 pll_tick counts without bypass", s_stb, 4'hF);
        pll_bypass = 1'b1;
        step(1'b1, 1'b0);
        chk(s_stb == 4'h0, "R7 pll_tick ignored in bypass", s_stb, 0);
        step(1'b0, 1'b1);
        chk(s_stb == 4'hF, "R7 ref_tick counts in bypass", s_stb, 4'hF);
        pll_bypass = 1'b0;
        write_ctrl(32'h0040_0001);
        run_ticks(100);
        for (int i = 0; i < 4 && !s_stb[0]; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0);
            chk(s_stb == 4'h0, "R8 idle cycle quiet", s_stb, 0);
        end
        step(1'b1, 1'b0);
        chk(s_stb[0] == 1'b0, "R8 cpu first tick after idle", s_stb[0], 0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        chk(s_stb[0] == 1'b1, "R8 cpu second tick after idle", s_stb[0], 1);
    endtask

    task automatic t_r9_aux();
        int cnt;
        bit prev;
        bit twice;
        write_ctrl(32'h0060_0000);
        chk(aux_full == 1'b1, "R9 aux_full set", aux_full, 1);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0);
            chk(s_aux == 1'b1, "R9 full rate aux", s_aux, 1);
        end
        write_ctrl(32'h0040_0000);
        chk(aux_full == 1'b0, "R9 aux_full clear", aux_full, 0);
        cnt = 0; prev = 0; twice = 0;
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0);
            if (s_aux) cnt++;
            if (s_aux && prev) twice = 1;
            prev = s_aux;
        end
        chk(cnt == 2, "R9 half rate aux count", cnt, 2);
        chk(!twice, "R9 half rate no back-to-back", twice, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        t_r1_reset();
        t_r2_table();
        t_r3_r4_saturate();
        t_r5_no_enable();
        t_r6_sync_apply();
        t_r7_r8_source();
        t_r9_aux();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule